// File: doc/BRIEF.md
# Gate Configuration Rule Checker

This block decides whether a small gate program is legal before anything evaluates it. The program has a fixed number of slots (fourteen by default). Each slot names a gate type, up to two source operands and a destination. An operand is either an external port (index 0 to 3) or a scratch register (index 0 to NUM_REGS-1, ten by default). A pulse on `start` begins a scan. The checker fetches one slot per clock through a combinational read port and keeps a mask of the scratch registers that earlier slots have written. It applies completeness, aliasing, define-before-use and write-once rules to each slot.

The scan ends at the first slot that breaks a rule, or after the final slot. On the cycle that ends it, `done` pulses for one cycle. Then `cfg_ok`, `err_code` and `err_slot` give the verdict. These outputs keep their values until the next accepted `start`. The surrounding logic keeps the slot storage and wires the slot with index `slot_addr` onto `slot_data` in the same cycle.

Top module: `gate_cfg_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done`, `cfg_ok`, `err_code` and `err_slot` are all cleared to zero.
- R2: If `start` is sampled high while the block is idle, slots are read in ascending order from index 0, one per clock. With the start-sampling edge counted as edge 0, `done` is high for exactly one cycle, right after edge j+1 for a fault at slot j, or right after edge NUM_SLOTS when the scan passes.
- R3: A slot word is {gate[20:18], src1[17:12], src2[11:6], dest[5:0]}. Each operand is {used[5], is_reg[4], idx[3:0]}. Gate codes are 0 none, 1 AND, 2 OR, 3 NOT, 4 XOR, 5 NAND, 6 BUF, 7 XNOR. A slot with gate 0 and no used operand is empty and is skipped. If every slot is empty or legal, the verdict is `cfg_ok`=1, `err_code`=0, `err_slot`=0.
- R4: A non-empty slot with gate code 0 fails with error code 1.
- R5: A NOT or BUF slot fails with code 2 if src1 is used, if src2 is unused, or if dest is unused.
- R6: Any other gate fails with code 3 if src1, src2 or dest is unused.
- R7: If src1 and src2 refer to the same register, or to the same port, the slot fails with code 4.
- R8: A destination register equal to either source register fails with code 5. A destination port equal to a source port is legal.
- R9: A source register must have been the destination of a strictly earlier slot. If it was not, the slot fails with code 6 when the register is in src1 and code 7 when it is in src2. A register index of NUM_REGS or above is never defined.
- R10: A destination register that an earlier slot already wrote fails with code 8. An out-of-range destination register also fails with code 8.
- R11: The scan stops at the first failing slot. `cfg_ok`=0, `err_code` holds that slot's code and `err_slot` holds its index. Later slots have no effect.
- R12: `start` is ignored while a scan runs. The verdict holds until the next accepted `start`. Each accepted `start` clears the written-register mask.
- R13: Within one slot, the rules are checked in this order: completeness (codes 1–3), identical sources (4), destination alias (5), src1 undefined (6), src2 undefined (7), rewrite (8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (accepted only when idle) |
| slot_addr | output | 4 | Index of the slot being read |
| slot_data | input | 21 | Contents of the slot at `slot_addr`, same cycle |
| done | output | 1 | One-cycle pulse at the end of a scan |
| cfg_ok | output | 1 | 1 when the last scan found no fault |
| err_code | output | 4 | Code of the fault, 0 if none |
| err_slot | output | 4 | Index of the first failing slot |

## Verification
The bench targets the rule collisions where a slot breaks more than one rule. One case writes a register again while also naming it as a source, so a design with the wrong check order reports code 8 where code 5 is due. Another case has both sources undefined, so swapping the two undefined codes shows up. Register definitions are only allowed to come from earlier slots. A mask updated too early, or not cleared on `start`, would accept a register that a later slot writes, or one left over from a previous scan. Faults at slot 0 and at the final slot, a second `start` during a scan, and the hold of the verdict after `done` test the scan counter and the end-of-scan timing.

// File: rtl/gcc_pkg.sv
// Package: shared field widths, slot layout, gate and fault codes for the
// gate configuration rule checker. Assumes register and port indices fit
// in OPIDX_W bits.
package gcc_pkg;
    localparam int OPIDX_W = 4;
    localparam int GATE_W  = 3;
    localparam int ERR_W   = 4;

    typedef enum logic [GATE_W-1:0] {
        G_NONE = 3'd0, G_AND = 3'd1, G_OR  = 3'd2, G_NOT  = 3'd3,
        G_XOR  = 3'd4, G_NAND = 3'd5, G_BUF = 3'd6, G_XNOR = 3'd7
    } gate_e;

    typedef struct packed {
        logic               used;
        logic               is_reg;
        logic [OPIDX_W-1:0] idx;
    } opnd_t;

    typedef struct packed {
        gate_e gate;
        opnd_t src1;
        opnd_t src2;
        opnd_t dest;
    } slot_t;

    localparam int SLOT_W = $bits(slot_t);

    typedef enum logic [ERR_W-1:0] {
        E_NONE         = 4'd0,
        E_NO_GATE      = 4'd1,
        E_UNARY_FORM   = 4'd2,
        E_BIN_MISSING  = 4'd3,
        E_SAME_SRC     = 4'd4,
        E_DEST_ALIAS   = 4'd5,
        E_SRC1_UNDEF   = 4'd6,
        E_SRC2_UNDEF   = 4'd7,
        E_DEST_REWRITE = 4'd8
    } err_e;

    // True when both operands are present and point at the same object.
    function automatic logic same_ref(opnd_t a, opnd_t b);
        return a.used && b.used && (a.is_reg == b.is_reg) && (a.idx == b.idx);
    endfunction
endpackage

// File: rtl/gcc_reg_lookup.sv
// Module: decodes one operand against the written-register mask.
// Assumes: an index of NUM_REGS or above names no register (one-hot is zero).
module gcc_reg_lookup
    import gcc_pkg::*;
#(
    parameter int NUM_REGS = 10
) (
    input  opnd_t               op,
    input  logic [NUM_REGS-1:0] written,
    output logic                reg_ref,
    output logic                defined,
    output logic [NUM_REGS-1:0] onehot
);
    // Operand refers to a scratch register at all.
    assign reg_ref = op.used && op.is_reg;

    // One-hot select of the named register, zero when out of range.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_hot
        assign onehot[k] = reg_ref && (op.idx == OPIDX_W'(k));
    end

    // Register has already been written by an earlier slot.
    assign defined = |(onehot & written);
endmodule

// File: rtl/gcc_rule_eval.sv
// Module: combinational rule check of one slot against the set of registers
// written so far. Outputs the fault code in fixed precedence order, and the
// destination register one-hot for a passing slot.
// Assumes: an empty slot always yields E_NONE and an all-zero dest_set.
module gcc_rule_eval
    import gcc_pkg::*;
#(
    parameter int NUM_REGS = 10
) (
    input  slot_t               slot,
    input  logic [NUM_REGS-1:0] written,
    output err_e                err,
    output logic [NUM_REGS-1:0] dest_set
);
    localparam int NUM_OPS = 3;

    opnd_t               ops    [NUM_OPS];
    logic                ref_v  [NUM_OPS];
    logic                def_v  [NUM_OPS];
    logic [NUM_REGS-1:0] hot_v  [NUM_OPS];
    logic                is_empty, unary;
    logic                miss_unary, miss_binary, alias_hit, rewrite_hit;

    assign ops[0] = slot.src1;
    assign ops[1] = slot.src2;
    assign ops[2] = slot.dest;

    // One register lookup per operand position.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_lk
        gcc_reg_lookup #(.NUM_REGS(NUM_REGS)) u_lk (
            .op      (ops[g]),
            .written (written),
            .reg_ref (ref_v[g]),
            .defined (def_v[g]),
            .onehot  (hot_v[g])
        );
    end

    // Slot shape classification.
    assign is_empty    = (slot.gate == G_NONE) && !slot.src1.used
                         && !slot.src2.used && !slot.dest.used;
    assign unary       = (slot.gate == G_NOT) || (slot.gate == G_BUF);
    assign miss_unary  = slot.src1.used || !slot.src2.used || !slot.dest.used;
    assign miss_binary = !slot.src1.used || !slot.src2.used || !slot.dest.used;
    assign alias_hit   = |(hot_v[2] & (hot_v[0] | hot_v[1]));
    assign rewrite_hit = ref_v[2] && (def_v[2] || (hot_v[2] == '0));

    // Fault selection in precedence order.
    always_comb begin
        err = E_NONE;
        if (is_empty)                            err = E_NONE;
        else if (slot.gate == G_NONE)            err = E_NO_GATE;
        else if (unary && miss_unary)            err = E_UNARY_FORM;
        else if (!unary && miss_binary)          err = E_BIN_MISSING;
        else if (same_ref(slot.src1, slot.src2)) err = E_SAME_SRC;
        else if (alias_hit)                      err = E_DEST_ALIAS;
        else if (ref_v[0] && !def_v[0])          err = E_SRC1_UNDEF;
        else if (ref_v[1] && !def_v[1])          err = E_SRC2_UNDEF;
        else if (rewrite_hit)                    err = E_DEST_REWRITE;
    end

    // Register to mark as written when the slot passes.
    assign dest_set = (err == E_NONE) ? hot_v[2] : '0;
endmodule

// File: rtl/gcc_reg_tracker.sv
// Module: holds the set of scratch registers written by slots already
// accepted in the current scan. Assumes set_mask is zero while clear is high.
module gcc_reg_tracker #(
    parameter int NUM_REGS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [NUM_REGS-1:0] set_mask,
    output logic [NUM_REGS-1:0] written
);
    // Clear on a new scan, otherwise accumulate accepted destinations.
    always_ff @(posedge clk) begin
        if (!rst_n)     written <= '0;
        else if (clear) written <= '0;
        else            written <= written | set_mask;
    end

    // R10
    write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> ((set_mask & written) == '0));

    // R12
    mask_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((written & $past(written)) == $past(written)));
endmodule

// File: rtl/gcc_scan_ctrl.sv
// Module: scan sequencer. Accepts start when idle, steps the slot index once
// per clock, stops at the first fault or after the last slot, and registers
// the verdict with a one-cycle done pulse.
// Assumes: err is E_NONE for empty slots.
module gcc_scan_ctrl
    import gcc_pkg::*;
#(
    parameter int NUM_SLOTS = 14
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  err_e                         err,
    output logic [$clog2(NUM_SLOTS)-1:0] slot_addr,
    output logic                         clear_mask,
    output logic                         upd_en,
    output logic                         done,
    output logic                         cfg_ok,
    output logic [ERR_W-1:0]             err_code,
    output logic [$clog2(NUM_SLOTS)-1:0] err_slot
);
    localparam int AW = $clog2(NUM_SLOTS);
    localparam logic [AW-1:0] LAST = AW'(NUM_SLOTS - 1);

    typedef enum logic {S_IDLE, S_SCAN} st_e;
    st_e  state;
    logic scanning, fault, at_last;

    // Status decode of the current cycle.
    assign scanning   = (state == S_SCAN);
    assign fault      = scanning && (err != E_NONE);
    assign at_last    = (slot_addr == LAST);
    assign clear_mask = !scanning && start;
    assign upd_en     = scanning && !fault;

    // Sequencer, index counter and verdict registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            slot_addr <= '0;
            done      <= 1'b0;
            cfg_ok    <= 1'b0;
            err_code  <= '0;
            err_slot  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    state     <= S_SCAN;
                    slot_addr <= '0;
                    cfg_ok    <= 1'b0;
                    err_code  <= '0;
                    err_slot  <= '0;
                end
                S_SCAN: begin
                    if (fault) begin
                        err_code <= err;
                        err_slot <= slot_addr;
                        done     <= 1'b1;
                        state    <= S_IDLE;
                    end else if (at_last) begin
                        cfg_ok <= 1'b1;
                        done   <= 1'b1;
                        state  <= S_IDLE;
                    end else begin
                        slot_addr <= slot_addr + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && start) |=> (!scanning || (slot_addr != '0)));

    // R12
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scanning && !start) |=> ($stable(cfg_ok) && $stable(err_code) && $stable(err_slot)));

    // R11
    verdict_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cfg_ok == (err_code == '0)));
endmodule

// File: rtl/gate_cfg_checker.sv
// Module: top of the gate configuration rule checker. Reads slots through a
// same-cycle read port, evaluates each against the written-register mask and
// reports the first fault. Assumes slot_data reflects slot_addr combinationally.
module gate_cfg_checker
    import gcc_pkg::*;
#(
    parameter int NUM_SLOTS = 14,
    parameter int NUM_REGS  = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic [$clog2(NUM_SLOTS)-1:0] slot_addr,
    input  logic [SLOT_W-1:0]            slot_data,
    output logic                         done,
    output logic                         cfg_ok,
    output logic [ERR_W-1:0]             err_code,
    output logic [$clog2(NUM_SLOTS)-1:0] err_slot
);
    slot_t               slot_w;
    err_e                err_w;
    logic [NUM_REGS-1:0] written_w, dest_set_w, set_mask_w;
    logic                clear_w, upd_w;

    assign slot_w     = slot_t'(slot_data);
    assign set_mask_w = upd_w ? dest_set_w : '0;

    gcc_rule_eval #(.NUM_REGS(NUM_REGS)) u_eval (
        .slot     (slot_w),
        .written  (written_w),
        .err      (err_w),
        .dest_set (dest_set_w)
    );

    gcc_reg_tracker #(.NUM_REGS(NUM_REGS)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear_w),
        .set_mask (set_mask_w),
        .written  (written_w)
    );

    gcc_scan_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .err        (err_w),
        .slot_addr  (slot_addr),
        .clear_mask (clear_w),
        .upd_en     (upd_w),
        .done       (done),
        .cfg_ok     (cfg_ok),
        .err_code   (err_code),
        .err_slot   (err_slot)
    );
endmodule

// File: tb/gate_cfg_checker_tb_top.sv
// Scoreboard bench: the driver loads a program, queues the expected verdict
// and pulses start; the monitor pops and compares on every done pulse.
module gate_cfg_checker_tb_top;
    localparam int NS = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  slot_addr;
    logic [20:0] slot_data;
    logic        done, cfg_ok;
    logic [3:0]  err_code, err_slot;

    logic [20:0] cfg [16];

    always #4 clk = ~clk;

    assign slot_data = cfg[slot_addr];

    gate_cfg_checker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .slot_addr(slot_addr),
        .slot_data(slot_data), .done(done), .cfg_ok(cfg_ok),
        .err_code(err_code), .err_slot(err_slot)
    );

    localparam logic [5:0] NO = 6'b0;
    function automatic logic [5:0] P(int i); return {2'b10, 4'(i)}; endfunction
    function automatic logic [5:0] R(int i); return {2'b11, 4'(i)}; endfunction
    function automatic logic [20:0] mk(int g, logic [5:0] a, logic [5:0] b, logic [5:0] d);
        return {3'(g), a, b, d};
    endfunction

    typedef struct {
        logic       ok;
        logic [3:0] code;
        logic [3:0] slot;
        int         lat;
        string      req;
    } exp_t;

    exp_t q[$];
    int   ntests = 0, nfail = 0;
    int   issued = 0, handled = 0;
    int   cyc = 0;
    bit   armed = 0;

    task automatic chk(string req, string what, int act, int exp);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < 16; i++) cfg[i] = '0;
    endtask

    // Counts rising edges since start was driven.
    always @(posedge clk) if (armed) cyc++;

    // Monitor: compares each verdict against the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (q.size() == 0) begin
                    ntests++; nfail++;
                    $display("FAIL R2 unexpected done: got 1 expected 0");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.req, "cfg_ok",   int'(cfg_ok),   int'(e.ok));
                    chk(e.req, "err_code", int'(err_code), int'(e.code));
                    chk(e.req, "err_slot", int'(err_slot), int'(e.slot));
                    chk("R2",  "latency",  cyc,            e.lat);
                end
                handled++;
                armed = 0;
            end
        end
    end

    // Driver: queue expectation, pulse start, optional extra start mid-scan.
    task automatic run_case(string req, logic ok, int code, int slot, int extra_at);
        exp_t e;
        e.ok = ok; e.code = 4'(code); e.slot = 4'(slot);
        e.lat = ok ? NS + 1 : slot + 2;
        e.req = req;
        q.push_back(e);
        issued++;
        @(negedge clk);
        start = 1'b1; cyc = 0; armed = 1;
        @(negedge clk);
        start = 1'b0;
        if (extra_at > 0) begin
            repeat (extra_at) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (handled < issued) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        ntests++; nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        clear_cfg();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "done",     int'(done),     0);
        chk("R1", "cfg_ok",   int'(cfg_ok),   0);
        chk("R1", "err_code", int'(err_code), 0);
        chk("R1", "err_slot", int'(err_slot), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 all slots empty
        run_case("R3", 1'b1, 0, 0, 0);

        // R3 R8 legal program with port destination equal to a source port
        clear_cfg();
        cfg[0] = mk(1, P(0), P(1), R(0));
        cfg[2] = mk(3, NO, R(0), R(1));
        cfg[3] = mk(4, R(0), R(1), P(2));
        cfg[4] = mk(2, P(0), P(1), P(0));
        cfg[5] = mk(6, NO, R(1), P(3));
        run_case("R3_R8", 1'b1, 0, 0, 0);

        // R4 non-empty slot without gate
        clear_cfg(); cfg[3] = mk(0, NO, NO, R(2));
        run_case("R4", 1'b0, 1, 3, 0);

        // R5 NOT with a first source
        clear_cfg(); cfg[0] = mk(3, P(0), P(1), R(0));
        run_case("R5", 1'b0, 2, 0, 0);

        // R12 verdict held after done
        repeat (5) @(negedge clk);
        chk("R12", "hold done",     int'(done),     0);
        chk("R12", "hold err_code", int'(err_code), 2);
        chk("R12", "hold err_slot", int'(err_slot), 0);

        // R5 BUF missing destination
        clear_cfg(); cfg[1] = mk(6, NO, P(1), NO);
        run_case("R5", 1'b0, 2, 1, 0);

        // R6 binary gate missing second source
        clear_cfg(); cfg[0] = mk(1, P(0), NO, R(0));
        run_case("R6", 1'b0, 3, 0, 0);

        // R7 same port twice
        clear_cfg(); cfg[0] = mk(7, P(2), P(2), R(0));
        run_case("R7", 1'b0, 4, 0, 0);

        // R7 same register twice
        clear_cfg(); cfg[0] = mk(1, P(0), P(1), R(0)); cfg[1] = mk(2, R(0), R(0), R(1));
        run_case("R7", 1'b0, 4, 1, 0);

        // R8 R13 destination aliases a source, also a rewrite: alias wins
        clear_cfg(); cfg[0] = mk(1, P(0), P(1), R(0)); cfg[1] = mk(2, R(0), P(2), R(0));
        run_case("R8_R13", 1'b0, 5, 1, 0);

        // R9 src1 written only by a later slot
        clear_cfg(); cfg[0] = mk(1, R(1), P(0), R(0)); cfg[1] = mk(2, P(0), P(1), R(1));
        run_case("R9", 1'b0, 6, 0, 0);

        // R9 src2 undefined
        clear_cfg(); cfg[0] = mk(1, P(0), P(1), R(0)); cfg[1] = mk(4, P(3), R(2), R(1));
        run_case("R9", 1'b0, 7, 1, 0);

        // R13 both sources undefined: src1 code wins
        clear_cfg(); cfg[0] = mk(1, R(1), R(2), R(0));
        run_case("R13", 1'b0, 6, 0, 0);

        // R10 register written twice
        clear_cfg(); cfg[0] = mk(1, P(0), P(1), R(0)); cfg[1] = mk(2, P(2), P(3), R(0));
        run_case("R10", 1'b0, 8, 1, 0);

        // R11 first of two faults reported
        clear_cfg(); cfg[2] = mk(0, P(0), NO, NO); cfg[5] = mk(1, P(0), P(0), R(0));
        run_case("R11", 1'b0, 1, 2, 0);

        // R11 R2 fault in the final slot
        clear_cfg(); cfg[0] = mk(1, P(0), P(1), R(0)); cfg[13] = mk(5, P(0), NO, P(1));
        run_case("R11", 1'b0, 3, 13, 0);

        // R3 chain writing every register once
        clear_cfg();
        cfg[0] = mk(1, P(0), P(1), R(0));
        for (int k = 1; k < 10; k++) cfg[k] = mk(3, NO, R(k - 1), R(k));
        cfg[10] = mk(6, NO, R(9), P(3));
        run_case("R3", 1'b1, 0, 0, 0);

        // R12 start during a scan is ignored
        clear_cfg(); cfg[8] = mk(0, NO, NO, R(1));
        run_case("R12", 1'b0, 1, 8, 3);

        // R12 mask cleared by a new start
        clear_cfg(); cfg[0] = mk(1, P(0), P(1), R(0));
        run_case("R12", 1'b1, 0, 0, 0);
        clear_cfg(); cfg[0] = mk(1, R(0), P(0), R(1));
        run_case("R12", 1'b0, 6, 0, 0);

        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule